// File: doc/BRIEF.md
# Converter Setup Write Sequencer

This block brings a high-speed data converter into one operating mode: complex decimation by eight, with 16-bit samples carried over a single serial LVDS lane. After a one-cycle `start` pulse it issues a fixed, ordered series of 22 register writes through its own write-only SPI serializer. The writes load the output bit mapper and pulse the fuse-load bit, with a timed pause between setting and clearing it. They then program the frame clock and its pattern, the 16-bit resolution and the decimation filter. The eight mixer frequency bytes and the Q-delay value come in on ports. The last two writes set the mixer gain and toggle its update.

The host holds the frequency word and Q-delay value on the ports and pulses `start`. The block captures both values, raises `busy`, and drives chip select, serial clock and data until the list is exhausted. It then drops `busy` and pulses `done` for a single cycle. The fuse-load pause and the serial clock rate are parameters, so a short pause can be used in simulation and the real 1 ms value on silicon.

Top module: `adc_cfg_seq`

## Requirements
- R1: While reset is high and on the first cycle after it falls, chip select is high, the serial clock is low, and `busy` and `done` are low.
- R2: Every write is one frame of exactly 24 serial clock rising edges, sent MSB first. Bit 23 is the write flag and is 0, bits 22..8 are the 15-bit register address, and bits 7..0 are the data byte.
- R3: The SPI runs in mode 0. The serial clock idles low and is low whenever chip select changes. The serial clock is high only while chip select is low. The data line holds steady for the whole time the serial clock is high.
- R4: The first three writes are, in order: 0x6C to address 0x07, then 0x01 to address 0x13, then 0x00 to address 0x13.
- R5: Between the end of the 0x13←0x01 frame and the start of the 0x13←0x00 frame, chip select stays high for at least PAUSE_CYCLES clock cycles.
- R6: Writes 4 to 10 are, in order: 0x19←0x80, 0x1B←0x88, 0x20←0xFF, 0x21←0xFF, 0x22←0x0F, 0x24←0x06, 0x25←0x30.
- R7: Writes 11 to 18 carry the frequency word. Byte k, which is `nco_word[8k+7:8k]`, goes to address 0x2A+k for k = 0..3 and to address 0x31+(k−4) for k = 4..7, in increasing k. The word is captured on the accepted start, so later changes on the port have no effect on the run.
- R8: Writes 19 and 20 send the Q-delay value, captured on the accepted start, to address 0x27 and then to address 0x2E.
- R9: Writes 21 and 22 are 0xAA to address 0x26, then 0x88 to address 0x26. Each run sends exactly 22 frames.
- R10: Chip select stays high for at least one full serial clock period (2·HALF_DIV clock cycles) between consecutive frames.
- R11: `busy` is high from the cycle after an accepted start until `done`. A `start` pulse while `busy` is high is ignored and adds no frames.
- R12: `done` is high for exactly one cycle after the last frame has completed, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| nco_word | input | 64 | Mixer frequency, byte k at bits 8k+7:8k |
| qdelay_val | input | 8 | Q-delay register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI serial clock, mode 0 |
| spi_mosi | output | 1 | SPI serial data out, MSB first |

## Verification
The bench decodes every frame from the pins and compares it with a list it builds itself. This catches a swapped frequency byte, a wrong address base, a dropped repeated write to 0x13 or 0x26, or frames that arrive out of order. It measures the idle time before each frame: a design that skips the fuse pause, or that chains frames without a clock-period gap, gives gaps that are too short. Mid-run it pulses `start` again and changes the frequency and Q-delay inputs. A design that restarts, or that reads the ports live instead of a captured copy, then sends extra frames or wrong bytes. A walking-bit sweep over all eight byte lanes exposes any slice or rotation error, and a done pulse longer than one cycle or one that overlaps busy is flagged.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int FRAME_W    = 24;
    localparam int ADDR_W     = 15;
    localparam int DATA_W     = 8;
    localparam int N_STEPS    = 22;
    localparam int STEP_W     = $clog2(N_STEPS);
    localparam int BITCNT_W   = $clog2(FRAME_W);
    localparam int FUSE_STEP  = 1;
    localparam int LAST_STEP  = N_STEPS - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_XFER,
        SQ_PAUSE
    } seq_state_t;

    typedef enum logic [1:0] {
        SR_IDLE,
        SR_SHIFT,
        SR_GAP
    } ser_state_t;

    function automatic reg_wr_t mk_wr(input logic [ADDR_W-1:0] a,
                                      input logic [DATA_W-1:0] d);
        reg_wr_t w;
        w.addr = a;
        w.data = d;
        return w;
    endfunction

    function automatic logic [FRAME_W-1:0] pack_frame(input reg_wr_t w);
        return {1'b0, w.addr, w.data};
    endfunction

endpackage

// File: rtl/adc_cfg_step_list.sv
module adc_cfg_step_list
    import adc_cfg_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [63:0]       nco_q,
    input  logic [7:0]        qdly_q,
    output reg_wr_t           wr
);

    // The frequency bytes go to two runs of four consecutive addresses.
    localparam logic [ADDR_W-1:0] NCO_LO_BASE = 15'h002A;
    localparam logic [ADDR_W-1:0] NCO_HI_BASE = 15'h0031;
    localparam int NCO_FIRST = 10;

    logic [2:0] nco_k;

    always_comb begin
        nco_k = 3'(int'(step) - NCO_FIRST);
        case (step)
            5'd0:  wr = mk_wr(15'h0007, 8'h6C);
            5'd1:  wr = mk_wr(15'h0013, 8'h01);
            5'd2:  wr = mk_wr(15'h0013, 8'h00);
            5'd3:  wr = mk_wr(15'h0019, 8'h80);
            5'd4:  wr = mk_wr(15'h001B, 8'h88);
            5'd5:  wr = mk_wr(15'h0020, 8'hFF);
            5'd6:  wr = mk_wr(15'h0021, 8'hFF);
            5'd7:  wr = mk_wr(15'h0022, 8'h0F);
            5'd8:  wr = mk_wr(15'h0024, 8'h06);
            5'd9:  wr = mk_wr(15'h0025, 8'h30);
            5'd10, 5'd11, 5'd12, 5'd13:
                   wr = mk_wr(NCO_LO_BASE + ADDR_W'(nco_k), nco_q[8*nco_k +: 8]);
            5'd14, 5'd15, 5'd16, 5'd17:
                   wr = mk_wr(NCO_HI_BASE + ADDR_W'(nco_k - 3'd4), nco_q[8*nco_k +: 8]);
            5'd18: wr = mk_wr(15'h0027, qdly_q);
            5'd19: wr = mk_wr(15'h002E, qdly_q);
            5'd20: wr = mk_wr(15'h0026, 8'hAA);
            default: wr = mk_wr(15'h0026, 8'h88);
        endcase
    end

endmodule

// File: rtl/adc_cfg_spi_ser.sv
module adc_cfg_spi_ser
    import adc_cfg_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               xfer_done,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi
);

    localparam int DIV_W = $clog2(2 * HALF_DIV + 1);
    localparam logic [DIV_W-1:0]    HALF_END = DIV_W'(HALF_DIV - 1);
    localparam logic [DIV_W-1:0]    GAP_END  = DIV_W'(2 * HALF_DIV - 1);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(FRAME_W - 1);

    ser_state_t           st;
    logic [FRAME_W-1:0]   shreg;
    logic [BITCNT_W-1:0]  bitcnt;
    logic [DIV_W-1:0]     divcnt;
    logic                 sclk_q;
    logic                 csn_q;
    logic                 done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SR_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            divcnt <= '0;
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                SR_IDLE: begin
                    if (load) begin
                        shreg  <= frame;
                        csn_q  <= 1'b0;
                        sclk_q <= 1'b0;
                        bitcnt <= '0;
                        divcnt <= '0;
                        st     <= SR_SHIFT;
                    end
                end
                SR_SHIFT: begin
                    if (divcnt == HALF_END) begin
                        divcnt <= '0;
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bitcnt == LAST_BIT) begin
                                csn_q <= 1'b1;
                                st    <= SR_GAP;
                            end else begin
                                shreg  <= {shreg[FRAME_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
                default: begin
                    if (divcnt == GAP_END) begin
                        divcnt <= '0;
                        done_q <= 1'b1;
                        st     <= SR_IDLE;
                    end else begin
                        divcnt <= divcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign cs_n      = csn_q;
    assign sclk      = sclk_q;
    assign mosi      = csn_q ? 1'b0 : shreg[FRAME_W-1];
    assign xfer_done = done_q;

endmodule

// File: rtl/adc_cfg_pause.sv
module adc_cfg_pause #(
    parameter int PAUSE_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expired
);

    localparam int CNT_W = $clog2(PAUSE_CYCLES + 1);

    logic [CNT_W-1:0] remain;
    logic             running;
    logic             fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain  <= '0;
            running <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (arm) begin
                remain  <= CNT_W'(PAUSE_CYCLES);
                running <= 1'b1;
            end else if (running) begin
                if (remain <= CNT_W'(1)) begin
                    running <= 1'b0;
                    fire_q  <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    assign expired = fire_q;

endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
    import adc_cfg_pkg::*;
#(
    parameter int HALF_DIV     = 4,
    parameter int PAUSE_CYCLES = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] nco_word,
    input  logic [7:0]  qdelay_val,
    output logic        busy,
    output logic        done,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi
);

    seq_state_t          state;
    logic [STEP_W-1:0]   step;
    logic [63:0]         nco_q;
    logic [7:0]          qdly_q;
    logic                done_q;
    reg_wr_t             cur_wr;
    logic                ser_load;
    logic                ser_done;
    logic                pause_arm;
    logic                pause_fire;

    adc_cfg_step_list u_list (
        .step   (step),
        .nco_q  (nco_q),
        .qdly_q (qdly_q),
        .wr     (cur_wr)
    );

    adc_cfg_spi_ser #(.HALF_DIV(HALF_DIV)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (ser_load),
        .frame     (pack_frame(cur_wr)),
        .xfer_done (ser_done),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi)
    );

    adc_cfg_pause #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_pause (
        .clk     (clk),
        .rst     (rst),
        .arm     (pause_arm),
        .expired (pause_fire)
    );

    assign ser_load  = (state == SQ_ISSUE);
    assign pause_arm = (state == SQ_XFER) && ser_done && (step == STEP_W'(FUSE_STEP));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            step   <= '0;
            nco_q  <= '0;
            qdly_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        nco_q  <= nco_word;
                        qdly_q <= qdelay_val;
                        step   <= '0;
                        state  <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state <= SQ_XFER;
                SQ_XFER: begin
                    if (ser_done) begin
                        if (step == STEP_W'(FUSE_STEP)) begin
                            state <= SQ_PAUSE;
                        end else if (step == STEP_W'(LAST_STEP)) begin
                            done_q <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            step  <= step + 1'b1;
                            state <= SQ_ISSUE;
                        end
                    end
                end
                default: begin
                    if (pause_fire) begin
                        step  <= step + 1'b1;
                        state <= SQ_ISSUE;
                    end
                end
            endcase
        end
    end

    assign busy = (state != SQ_IDLE);
    assign done = done_q;

endmodule

// File: rtl/adc_cfg_seq_chk.sv
module adc_cfg_seq_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);

    localparam int GAP_MIN = 2 * HALF_DIV;

    int unsigned idle_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run <= 32'(GAP_MIN);
        end else if (!spi_cs_n) begin
            idle_run <= 0;
        end else if (idle_run < 32'(GAP_MIN)) begin
            idle_run <= idle_run + 1;
        end
    end

    // R1
    reset_exit_chk: assert property (@(posedge clk)
        $fell(rst) |-> (spi_cs_n && !spi_sclk && !busy && !done));

    // R3
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);

    // R3
    cs_edge_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !spi_sclk);

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R10
    frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (idle_run >= 32'(GAP_MIN)));

    // R11
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R12
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

bind adc_cfg_seq adc_cfg_seq_chk #(.HALF_DIV(HALF_DIV)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi)
);

// File: tb/adc_cfg_seq_tb_top.sv
module adc_cfg_seq_tb_top;

    localparam int H      = 2;
    localparam int PAUSE  = 40;
    localparam int NFR    = 22;
    localparam int WDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] nco_word = '0;
    logic [7:0]  qdelay_val = '0;
    logic        busy, done, spi_cs_n, spi_sclk, spi_mosi;

    always #2 clk = ~clk;

    adc_cfg_seq #(.HALF_DIV(H), .PAUSE_CYCLES(PAUSE)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .nco_word   (nco_word),
        .qdelay_val (qdelay_val),
        .busy       (busy),
        .done       (done),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    logic [23:0] frames [0:31];
    int          bits_of [0:31];
    int          gap_of  [0:31];
    int          nfr, done_cnt, mode_bad, busy_bad, dbl, bits, last_end;
    logic [23:0] shft;
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_done = 1'b0;

    // Pin-level SPI slave model, sampled away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (!spi_cs_n && spi_sclk && !p_sclk) begin
                shft = {shft[22:0], spi_mosi};
                bits = bits + 1;
            end
            if (spi_cs_n && !p_cs) begin
                if (nfr < 32) begin
                    frames[nfr]  = shft;
                    bits_of[nfr] = bits;
                end
                nfr = nfr + 1;
                last_end = cyc;
                if (spi_sclk) mode_bad = mode_bad + 1;
            end
            if (!spi_cs_n && p_cs) begin
                shft = '0;
                bits = 0;
                if (nfr < 32) gap_of[nfr] = cyc - last_end;
                if (spi_sclk) mode_bad = mode_bad + 1;
            end
            if (spi_cs_n && spi_sclk) mode_bad = mode_bad + 1;
            if (done) begin
                done_cnt = done_cnt + 1;
                if (busy) busy_bad = busy_bad + 1;
            end
            if (done && p_done) dbl = dbl + 1;
        end
        p_sclk = spi_sclk;
        p_cs   = spi_cs_n;
        p_done = done;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected frame i, built from the requirement text.
    function automatic logic [23:0] exp_frame(input int i, input logic [63:0] nco,
                                              input logic [7:0] qd);
        logic [14:0] a;
        logic [7:0]  d;
        case (i)
            0:  begin a = 15'h07; d = 8'h6C; end
            1:  begin a = 15'h13; d = 8'h01; end
            2:  begin a = 15'h13; d = 8'h00; end
            3:  begin a = 15'h19; d = 8'h80; end
            4:  begin a = 15'h1B; d = 8'h88; end
            5:  begin a = 15'h20; d = 8'hFF; end
            6:  begin a = 15'h21; d = 8'hFF; end
            7:  begin a = 15'h22; d = 8'h0F; end
            8:  begin a = 15'h24; d = 8'h06; end
            9:  begin a = 15'h25; d = 8'h30; end
            18: begin a = 15'h27; d = qd; end
            19: begin a = 15'h2E; d = qd; end
            20: begin a = 15'h26; d = 8'hAA; end
            21: begin a = 15'h26; d = 8'h88; end
            default: begin
                d = nco[8*(i-10) +: 8];
                a = (i < 14) ? 15'(42 + (i - 10)) : 15'(49 + (i - 14));
            end
        endcase
        return {1'b0, a, d};
    endfunction

    function automatic string req_of(input int i);
        if (i < 3)  return "R4";
        if (i < 10) return "R6";
        if (i < 18) return "R7";
        if (i < 20) return "R8";
        return "R9";
    endfunction

    task automatic run_seq(input logic [63:0] nco, input logic [7:0] qd, input bit poke);
        int w;
        nfr = 0; done_cnt = 0; mode_bad = 0; busy_bad = 0; dbl = 0;
        last_end = cyc - 1000;
        @(negedge clk);
        nco_word = nco; qdelay_val = qd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", busy, 1);
        if (poke) begin
            repeat (300) @(negedge clk);
            nco_word = ~nco; qdelay_val = ~qd; start = 1'b1;   // R11, R7: ignored
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (done_cnt == 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(done_cnt > 0, "R12", "done seen", done_cnt, 1);
        repeat (60) @(negedge clk);
        check(nfr == NFR, "R9", "frame count", nfr, NFR);
        check(done_cnt == 1 && dbl == 0, "R12", "single-cycle done", done_cnt, 1);
        check(busy_bad == 0 && !busy, "R12", "busy low at done", busy_bad, 0);
        check(mode_bad == 0, "R3", "mode 0 clock at cs edges", mode_bad, 0);
        for (int i = 0; i < NFR && i < nfr; i++) begin
            check(bits_of[i] == 24, "R2", $sformatf("frame %0d edges", i), bits_of[i], 24);
            check(frames[i] == exp_frame(i, nco, qd), req_of(i),
                  $sformatf("frame %0d content", i), frames[i], exp_frame(i, nco, qd));
            check(frames[i][23] == 1'b0, "R2", $sformatf("frame %0d write flag", i),
                  frames[i][23], 0);
            if (i >= 1)
                check(gap_of[i] >= 2 * H, "R10", $sformatf("gap before %0d", i),
                      gap_of[i], 2 * H);
        end
        if (nfr > 2) check(gap_of[2] >= PAUSE, "R5", "fuse pause", gap_of[2], PAUSE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy && !done, "R1", "state in reset",
              {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n && !spi_sclk && !busy && !done, "R1", "state after reset",
              {spi_cs_n, spi_sclk, busy, done}, 4'b1000);
        repeat (5) @(negedge clk);
        check(nfr == 0 && spi_cs_n, "R11", "no frames without start", nfr, 0);

        run_seq(64'h0, 8'h00, 1'b0);
        run_seq(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b0);
        run_seq(64'h0123_4567_89AB_CDEF, 8'h08, 1'b1);
        // Walking-bit sweep over every byte lane (R7, R8).
        for (int b = 0; b < 8; b++) begin
            logic [63:0] v;
            for (int k = 0; k < 8; k++) v[8*k +: 8] = 8'(1 << ((k + b) % 8));
            run_seq(v, 8'(1 << b), (b == 5));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        while (cyc < WDOG) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule